// File: doc/BRIEF.md
# Split-Aware Priority Bus Arbiter

This arbiter decides which of two masters drives a shared one-bit serial bus. Requests are looked at only while the bus is free. Master 1 beats master 2 whenever both ask at once. The winner keeps its grant for as long as it holds its request line. Once it drops the line, the bus goes free on the next clock.

One slave can be slow. It may answer a transaction by raising a split line. When that happens, the arbiter stores which master owned the transaction, takes the grant away, and lends the bus to the other master. The stored owner stays parked, and its request line is not honoured while it waits. Later the slave signals that it is ready. The arbiter then hands the bus straight back to the parked owner, ahead of normal priority, and marks that grant with a one-cycle resume pulse. If the bus is lent out when the ready indication comes, the resume is remembered and carried out as soon as the borrower lets go. Only one split can be outstanding at a time.

Top module: `split_prio_arbiter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both grants, the resume pulse and any stored split owner. After reset the outputs are `gnt_o == 2'b00` and `split_gnt_o == 0`.
- R2: When the bus is free, no resume is due and both masters request, the next cycle shows `gnt_o == 2'b01`. Bit 0 is master 1 and bit 1 is master 2. A lone request from either master is granted in the same way one cycle later.
- R3: At most one bit of `gnt_o` is high in any cycle. `split_gnt_o` is high only together with a grant.
- R4: A granted master keeps its grant while its request stays high and no new split occurs. In the cycle after it drops its request, `gnt_o == 2'b00`.
- R5: If `split_i` is high while a master is granted and no split is outstanding, that master becomes the split owner and the next cycle shows `gnt_o == 2'b00`.
- R6: While a split is outstanding, the owner's request is ignored, and the other master can be granted the bus.
- R7: If `resume_i` is high while a split is outstanding and the bus is free, the next cycle grants the owner and raises `split_gnt_o` for exactly one cycle.
- R8: If `resume_i` arrives while the other master holds the bus, the resume is kept. In the first free cycle after that transaction ends, the owner is granted with `split_gnt_o` high, even when master 1 is also requesting.
- R9: `split_i` has no effect while a split is already outstanding or while no master is granted.
- R10: After the resume grant the split state is clear. A later `resume_i` raises no `split_gnt_o`, and the former owner's requests are honoured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 2 | Bus requests; bit 0 is master 1, bit 1 is master 2 |
| split_i | input | 1 | Split request from the split-capable slave |
| resume_i | input | 1 | Split slave is ready to resume |
| gnt_o | output | 2 | Bus grants, same bit order as req_i |
| split_gnt_o | output | 1 | One-cycle resume pulse issued with the owner's grant |

## Verification
The directed cases cover the situations that are easiest to get wrong:

- A resume that lands while the bus is lent out. A design that drops it would leave the owner parked for good. A design that acts on it at once would overlap two grants.
- The deferred resume in a cycle where master 1 also requests. A design that applies plain priority there would skip the owner.
- A second split raised while one is already stored. A design that accepts it would overwrite the stored owner.
- The owner's own request during a split. A design that honours it would grant the owner with no resume pulse.

Long random runs of requests, splits and resumes are compared cycle by cycle against a reference model kept in the bench. This catches release timing that is off by one cycle and resume pulses that last too long.

// File: rtl/split_prio_arbiter.sv
module split_prio_arbiter (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req_i,
  input  logic       split_i,
  input  logic       resume_i,
  output logic [1:0] gnt_o,
  output logic       split_gnt_o
);
  logic [1:0] gnt_q;
  logic       pend_q, own_q, rsv_q, sg_q;

  wire       idle       = (gnt_q == 2'b00);
  wire       cur        = gnt_q[1];
  wire       resume_now = pend_q & (rsv_q | resume_i);
  wire [1:0] req_eff    = req_i & ~{pend_q & own_q, pend_q & ~own_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= 2'b00;
      pend_q <= 1'b0;
      own_q  <= 1'b0;
      rsv_q  <= 1'b0;
      sg_q   <= 1'b0;
    end else begin
      sg_q <= 1'b0;
      if (pend_q & resume_i) rsv_q <= 1'b1;
      if (idle) begin
        if (resume_now) begin
          gnt_q  <= own_q ? 2'b10 : 2'b01;
          sg_q   <= 1'b1;
          pend_q <= 1'b0;
          rsv_q  <= 1'b0;
        end else if (req_eff[0]) begin
          gnt_q <= 2'b01;
        end else if (req_eff[1]) begin
          gnt_q <= 2'b10;
        end
      end else if (split_i & ~pend_q) begin
        pend_q <= 1'b1;
        own_q  <= cur;
        gnt_q  <= 2'b00;
      end else if (!req_i[cur]) begin
        gnt_q <= 2'b00;
      end
    end
  end

  assign gnt_o       = gnt_q;
  assign split_gnt_o = sg_q;
endmodule

module split_prio_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] req_i,
  input logic       split_i,
  input logic [1:0] gnt_o,
  input logic       split_gnt_o,
  input logic       pend
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_o));
  // R3
  resume_with_grant_chk: assert property (@(posedge clk) disable iff (rst) split_gnt_o |-> (gnt_o != 2'b00));
  // R2
  m1_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == 2'b00 && !pend && req_i == 2'b11) |=> (gnt_o == 2'b01));
  // R4
  hold_m1_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o[0] && req_i[0] && !split_i) |=> gnt_o[0]);
  // R4
  hold_m2_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o[1] && req_i[1] && !split_i) |=> gnt_o[1]);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt_o[0] && !req_i[0]) || (gnt_o[1] && !req_i[1])) |=> (gnt_o == 2'b00));
  // R5
  split_release_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != 2'b00 && split_i && !pend) |=> (gnt_o == 2'b00 && pend));
  // R7
  resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    split_gnt_o |=> !split_gnt_o);
  // R10
  resume_clears_chk: assert property (@(posedge clk) disable iff (rst)
    split_gnt_o |-> !pend);
endmodule

bind split_prio_arbiter split_prio_arbiter_chk chk_i (
  .clk(clk), .rst(rst), .req_i(req_i), .split_i(split_i),
  .gnt_o(gnt_o), .split_gnt_o(split_gnt_o), .pend(pend_q)
);

// File: tb/split_prio_arbiter_tb.sv
`timescale 1ns/1ps
module split_prio_arbiter_tb_top;
  logic clk = 0, rst = 1;
  logic [1:0] req_i = 0;
  logic split_i = 0, resume_i = 0;
  logic [1:0] gnt_o;
  logic split_gnt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] m_gnt;
  logic m_pend, m_own, m_rsv, m_sg;

  always #2.5 clk = ~clk;

  split_prio_arbiter dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .split_i(split_i),
    .resume_i(resume_i), .gnt_o(gnt_o), .split_gnt_o(split_gnt_o)
  );

  function automatic logic [1:0] onehot(input logic idx);
    return idx ? 2'b10 : 2'b01;
  endfunction

  task automatic model_next(input logic [1:0] r, input logic s, input logic rs, input logic rr);
    logic [1:0] g; logic p, o, v, sg; logic [1:0] eff; logic k;
    g = m_gnt; p = m_pend; o = m_own; v = m_rsv; sg = 0;
    if (rr) begin g = 0; p = 0; o = 0; v = 0; sg = 0; end
    else begin
      eff = r;
      if (m_pend) eff[m_own] = 1'b0;
      if (m_pend && rs) v = 1;
      if (m_gnt == 2'b00) begin
        if (m_pend && (m_rsv || rs)) begin g = onehot(m_own); sg = 1; p = 0; v = 0; end
        else if (eff[0]) g = 2'b01;
        else if (eff[1]) g = 2'b10;
      end else begin
        k = m_gnt[1];
        if (s && !m_pend) begin p = 1; o = k; g = 0; end
        else if (!r[k]) g = 0;
      end
    end
    m_gnt = g; m_pend = p; m_own = o; m_rsv = v; m_sg = sg;
  endtask

  task automatic check(input string tag, input logic [1:0] g_exp, input logic sg_exp);
    n_chk++;
    if (gnt_o !== g_exp || split_gnt_o !== sg_exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b sg=%b expected gnt=%b sg=%b at %0t", tag, gnt_o, split_gnt_o, g_exp, sg_exp, $time);
    end
    if (!$onehot0(gnt_o) || (split_gnt_o && gnt_o == 2'b00)) begin
      n_chk++; n_fail++;
      $display("FAIL R3: gnt=%b sg=%b expected onehot0 grant with pulse", gnt_o, split_gnt_o);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] r, input logic s, input logic rs, input logic rr = 0);
    @(negedge clk);
    req_i = r; split_i = s; resume_i = rs; rst = rr;
    model_next(r, s, rs, rr);
    @(posedge clk); #1;
    check(tag, m_gnt, m_sg);
  endtask

  initial begin
    m_gnt = 0; m_pend = 0; m_own = 0; m_rsv = 0; m_sg = 0;
    step("R1", 2'b11, 0, 0, 1);
    step("R1", 2'b00, 0, 0, 1);
    check("R1", 2'b00, 0);
    // R2 both request from idle
    step("R2", 2'b11, 0, 0);
    check("R2", 2'b01, 0);
    // R4 hold then release
    step("R4", 2'b11, 0, 0);
    step("R4", 2'b11, 0, 0);
    check("R4", 2'b01, 0);
    step("R4", 2'b10, 0, 0);
    check("R4", 2'b00, 0);
    step("R2", 2'b10, 0, 0);
    check("R2", 2'b10, 0);
    // R9 split while idle ignored
    step("R9", 2'b00, 0, 0);
    step("R9", 2'b00, 1, 0);
    check("R9", 2'b00, 0);
    // R5 split by master 2
    step("R5", 2'b10, 0, 0);
    step("R5", 2'b10, 1, 0);
    check("R5", 2'b00, 0);
    // R6 owner ignored, master 1 borrows
    step("R6", 2'b10, 0, 0);
    check("R6", 2'b00, 0);
    step("R6", 2'b11, 0, 0);
    check("R6", 2'b01, 0);
    // R9 second split ignored while pending
    step("R9", 2'b11, 1, 0);
    check("R9", 2'b01, 0);
    // R8 resume while borrowed
    step("R8", 2'b11, 0, 1);
    check("R8", 2'b01, 0);
    step("R8", 2'b11, 0, 0);
    step("R8", 2'b10, 0, 0);
    check("R8", 2'b00, 0);
    step("R8", 2'b11, 0, 0);
    check("R8", 2'b10, 1);
    step("R7", 2'b11, 0, 0);
    check("R7", 2'b10, 0);
    // R10 resume after clear has no effect
    step("R10", 2'b00, 0, 1);
    step("R10", 2'b00, 0, 1);
    check("R10", 2'b00, 0);
    step("R10", 2'b10, 0, 0);
    check("R10", 2'b10, 0);
    // R7 resume on idle bus, owner master 1
    step("R7", 2'b01, 0, 0);
    step("R7", 2'b01, 0, 0);
    step("R7", 2'b01, 0, 0);
    check("R7", 2'b01, 0);
    step("R7", 2'b01, 1, 0);
    check("R7", 2'b00, 0);
    step("R7", 2'b00, 0, 1);
    check("R7", 2'b01, 1);
    step("R7", 2'b00, 0, 0);
    check("R7", 2'b00, 0);
    // random phase
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] r; logic s, rs, rr;
      r  = 2'($urandom_range(0, 3));
      s  = ($urandom_range(0, 7) == 0);
      rs = ($urandom_range(0, 9) == 0);
      rr = ($urandom_range(0, 499) == 0);
      step("R2/R4/R5/R6/R8", r, s, rs, rr);
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule